// File: doc/BRIEF.md
# Coprocessor Handshake Controller

This controller sits on the processor side of a coprocessor attachment in which the coprocessors watch the instruction stream and answer over two shared wires. Up to sixteen logical coprocessors may hang on those wires. When a coprocessor instruction reaches execute, the controller first decides whether the instruction is eligible. An instruction that failed its condition test, or that sits in the shadow of a taken branch, is dropped silently. An eligible instruction is offered by pulling an active-low offer line.

While the offer line is low, the controller samples the shared "absent" and "busy" answers at each clock edge. If no coprocessor claims the instruction, the result is an undefined-instruction trap. If one claims it and is free, the instruction completes. If one claims it but is busy, the controller holds the offer and stalls the instruction stream until the busy line falls. An interrupt that arrives while the coprocessor is still busy makes the controller give up the instruction and take the interrupt. The pipeline presents the abandoned instruction again later.

Top module: `cop_handshake_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `offer_n` is 1 and `stall`, `undef_trap`, `take_irq` and `done` are 0.
- R2: `insn_valid` high in the idle state with `cond_ok` low or `in_shadow` high leaves `offer_n` at 1 in the next two cycles and raises no outcome pulse, whatever `cp_absent` and `cp_busy` show.
- R3: `insn_valid` high in the idle state with `cond_ok` high and `in_shadow` low drives `offer_n` to 0 in the next cycle (the offer cycle).
- R4: When `cp_absent` is 1 at the end of the offer cycle, `undef_trap` is 1 for the following cycle and `offer_n` is back at 1.
- R5: When `cp_absent` and `cp_busy` are both 0 at the end of the offer cycle, `done` is 1 for the following cycle, `offer_n` is 1 and `stall` is 0.
- R6: When `cp_absent` is 0 and `cp_busy` is 1 at the end of the offer cycle, the controller enters a busy-wait. In every busy-wait cycle in which `cp_busy` is 1, `offer_n` is 0 and `stall` is 1.
- R7: In the busy-wait cycle in which `cp_busy` is 0, `stall` is already 0. `done` is 1 in the next cycle, with `offer_n` at 1.
- R8: `irq_req` high in a busy-wait cycle in which `cp_busy` is still 1 abandons the instruction. `take_irq` is 1 in the next cycle, `offer_n` is 1 and `done` stays 0. A later re-presentation of the same instruction is offered afresh.
- R9: During the busy-wait, `insn_valid` and `cp_absent` have no effect. No trap is raised and `stall` stays 1 while `cp_busy` is 1.
- R10: `undef_trap`, `take_irq` and `done` are one-cycle pulses, and at most one of them is 1 in any cycle.
- R11: When `cp_busy` is 0 and `irq_req` is 1 in the same busy-wait cycle, completion wins. `done` pulses and `take_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | A coprocessor instruction is in execute (sampled only when idle) |
| cond_ok | input | 1 | The instruction passed its condition test |
| in_shadow | input | 1 | The instruction lies in a branch shadow |
| cp_absent | input | 1 | Shared answer: no coprocessor accepts the instruction |
| cp_busy | input | 1 | Shared answer: the accepting coprocessor cannot start yet |
| irq_req | input | 1 | Enabled interrupt request |
| offer_n | output | 1 | Active-low offer of the instruction to the coprocessors |
| stall | output | 1 | Hold the instruction stream |
| undef_trap | output | 1 | Pulse: take the undefined-instruction trap |
| take_irq | output | 1 | Pulse: instruction abandoned, take the interrupt |
| done | output | 1 | Pulse: coprocessor instruction completed |

## Verification
The controller has no parameters, so the bench builds it as it stands. What brings behaviour within reach is the stimulus. The bench uses busy-waits of one to four cycles, an interrupt on the last busy cycle followed by a retry, and an interrupt in the same cycle as the busy drop. It also applies noise on `insn_valid` and `cp_absent` during a wait, and skips under each of the two skip conditions while the response wires are set. Back-to-back instructions show that every outcome returns the controller to a state that accepts the next instruction at once.

// File: rtl/cpho_pkg.sv
package cpho_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } cpho_state_e;

  typedef enum logic [1:0] {
    RSP_TRAP = 2'd0,
    RSP_WAIT = 2'd1,
    RSP_GO   = 2'd2
  } cpho_rsp_e;

  // Eligibility: a valid instruction that passed its condition and is not shadowed.
  function automatic logic may_offer(input logic valid, input logic cond_pass,
                                     input logic shadowed);
    return valid & cond_pass & ~shadowed;
  endfunction

  // Meaning of the shared answer wires at the end of an offer cycle.
  function automatic cpho_rsp_e classify(input logic absent, input logic busy);
    if (absent)    return RSP_TRAP;
    else if (busy) return RSP_WAIT;
    else           return RSP_GO;
  endfunction

endpackage

// File: rtl/cpho_gate.sv
module cpho_gate (
  input  logic insn_valid,
  input  logic cond_ok,
  input  logic in_shadow,
  output logic offer_go,
  output logic offer_skip
);
  import cpho_pkg::*;

  always_comb begin
    offer_go   = may_offer(insn_valid, cond_ok, in_shadow);
    offer_skip = insn_valid & ~offer_go;
  end

endmodule

// File: rtl/cpho_fsm.sv
module cpho_fsm
  import cpho_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        offer_go,
  input  logic        cp_absent,
  input  logic        cp_busy,
  input  logic        irq_req,
  output cpho_state_e state_o,
  output logic        offer_n,
  output logic        stall,
  output logic        undef_trap,
  output logic        take_irq,
  output logic        done
);

  cpho_state_e state, nxt;
  cpho_rsp_e   rsp;
  logic        ev_trap;
  logic        ev_abandon;
  logic        trap_q;
  logic        irq_q;

  always_comb begin
    rsp        = classify(cp_absent, cp_busy);
    nxt        = state;
    ev_trap    = 1'b0;
    ev_abandon = 1'b0;
    case (state)
      ST_IDLE:  if (offer_go) nxt = ST_OFFER;
      ST_OFFER: begin
        case (rsp)
          RSP_TRAP: begin nxt = ST_IDLE; ev_trap = 1'b1; end
          RSP_WAIT: nxt = ST_WAIT;
          default:  nxt = ST_DONE;
        endcase
      end
      ST_WAIT: begin
        if (!cp_busy)     nxt = ST_DONE;
        else if (irq_req) begin nxt = ST_IDLE; ev_abandon = 1'b1; end
      end
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      trap_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      state  <= nxt;
      trap_q <= ev_trap;
      irq_q  <= ev_abandon;
    end
  end

  always_comb begin
    state_o    = state;
    offer_n    = ~((state == ST_OFFER) || (state == ST_WAIT));
    stall      = (state == ST_WAIT) && cp_busy;
    undef_trap = trap_q;
    take_irq   = irq_q;
    done       = (state == ST_DONE);
  end

  // R4: no claimant at the end of the offer cycle leads to a trap
  a_r4_absent_traps: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFFER && cp_absent) |=> (undef_trap && offer_n));

  // R5: claimed and free leads to immediate completion
  a_r5_free_completes: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFFER && !cp_absent && !cp_busy) |=> (done && !stall));

  // R6: claimed but busy keeps the offer up
  a_r6_busy_holds_offer: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFFER && !cp_absent && cp_busy) |=> !offer_n);

  // R6: a stall is only raised while the instruction is on offer
  a_r6_stall_offered: assert property (@(posedge clk) disable iff (rst)
    stall |-> !offer_n);

  // R7 / R11: busy falling finishes the instruction
  a_r7_drop_completes: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !cp_busy) |=> (done && !take_irq));

  // R8: interrupt during a busy wait abandons the instruction
  a_r8_irq_abandons: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && cp_busy && irq_req) |=> (take_irq && offer_n && !done));

  // R9: absent answer is not acted on during the wait
  a_r9_wait_ignores_absent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && cp_busy && !irq_req) |=> (!undef_trap && !offer_n));

  // R10: outcome pulses are exclusive and last one cycle
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({undef_trap, take_irq, done}));
  a_r10_trap_single: assert property (@(posedge clk) disable iff (rst)
    undef_trap |=> !undef_trap);
  a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/cop_handshake_ctrl.sv
module cop_handshake_ctrl
  import cpho_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic insn_valid,
  input  logic cond_ok,
  input  logic in_shadow,
  input  logic cp_absent,
  input  logic cp_busy,
  input  logic irq_req,
  output logic offer_n,
  output logic stall,
  output logic undef_trap,
  output logic take_irq,
  output logic done
);

  logic        offer_go;
  logic        offer_skip;
  cpho_state_e fsm_state;

  cpho_gate u_gate (
    .insn_valid (insn_valid),
    .cond_ok    (cond_ok),
    .in_shadow  (in_shadow),
    .offer_go   (offer_go),
    .offer_skip (offer_skip)
  );

  cpho_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .offer_go   (offer_go),
    .cp_absent  (cp_absent),
    .cp_busy    (cp_busy),
    .irq_req    (irq_req),
    .state_o    (fsm_state),
    .offer_n    (offer_n),
    .stall      (stall),
    .undef_trap (undef_trap),
    .take_irq   (take_irq),
    .done       (done)
  );

  // R2: a skipped instruction is never offered and produces no outcome
  a_r2_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE && offer_skip) |=> (offer_n && !done && !stall));

  // R3: an eligible instruction in idle is offered next cycle
  a_r3_offer_next: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE && offer_go) |=> !offer_n);

  // R1: first cycle after reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> (offer_n && !stall && !undef_trap && !take_irq && !done));

endmodule

// File: tb/test_cop_handshake_ctrl.sv
module test_cop_handshake_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int EV_TRAP = 1;
  localparam int EV_IRQ  = 2;
  localparam int EV_DONE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic insn_valid = 1'b0, cond_ok = 1'b0, in_shadow = 1'b0;
  logic cp_absent = 1'b0, cp_busy = 1'b0, irq_req = 1'b0;
  logic offer_n, stall, undef_trap, take_irq, done;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];
  logic [2:0] prev_pulse = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_handshake_ctrl i_cop_handshake_ctrl (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .cond_ok(cond_ok),
    .in_shadow(in_shadow), .cp_absent(cp_absent), .cp_busy(cp_busy),
    .irq_req(irq_req), .offer_n(offer_n), .stall(stall),
    .undef_trap(undef_trap), .take_irq(take_irq), .done(done)
  );

  task automatic check_eq(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops the expected outcome whenever a pulse appears (R10 ordering/exclusivity)
  always @(negedge clk) begin
    logic [2:0] p;
    int kind, want;
    p = {undef_trap, take_irq, done};
    if (!rst && p != 3'b000) begin
      check_eq("R10", {7'd0, $onehot(p)}, 8'd1);
      check_eq("R10", {5'd0, p & prev_pulse}, 8'd0);
      kind = undef_trap ? EV_TRAP : (take_irq ? EV_IRQ : EV_DONE);
      if (exp_q.size() == 0) begin
        check_eq("R10", kind[7:0], 8'd0);
      end else begin
        want = exp_q.pop_front();
        check_eq(want == EV_TRAP ? "R4" : (want == EV_IRQ ? "R8" : "R5"),
                 kind[7:0], want[7:0]);
      end
    end
    prev_pulse = rst ? 3'b000 : p;
  end

  // Driver: one coprocessor instruction through its whole handshake
  task automatic issue(input bit cond, input bit shadow, input bit absent,
                       input int nbusy, input bit irq_last, input bit irq_drop,
                       input bit noise);
    @(posedge clk); #1;
    insn_valid = 1'b1; cond_ok = cond; in_shadow = shadow;
    cp_absent = absent; cp_busy = (nbusy > 0); irq_req = 1'b0;
    @(posedge clk); #1;
    insn_valid = 1'b0;
    if (!cond || shadow) begin
      check_eq("R2", {5'd0, offer_n, undef_trap, done}, 8'b100);
      @(posedge clk); #1;
      check_eq("R2", {4'd0, offer_n, undef_trap, take_irq, done}, 8'b1000);
      cp_absent = 1'b0; cp_busy = 1'b0;
      return;
    end
    check_eq("R3", {7'd0, offer_n}, 8'd0);
    if (absent) begin
      exp_q.push_back(EV_TRAP);
      @(posedge clk); #1;
      check_eq("R4", {5'd0, undef_trap, offer_n, stall}, 8'b110);
      cp_absent = 1'b0; cp_busy = 1'b0;
      return;
    end
    if (nbusy == 0) begin
      exp_q.push_back(EV_DONE);
      @(posedge clk); #1;
      check_eq("R5", {5'd0, done, offer_n, stall}, 8'b110);
      return;
    end
    for (int i = 0; i < nbusy; i++) begin
      @(posedge clk); #1;
      if (noise && i > 0) check_eq("R9", {6'd0, stall, undef_trap}, 8'b10);
      check_eq("R6", {6'd0, stall, offer_n}, 8'b10);
      if (noise) begin insn_valid = 1'b1; cp_absent = 1'b1; end
      if (irq_last && i == nbusy - 1) begin
        irq_req = 1'b1;
        exp_q.push_back(EV_IRQ);
        @(posedge clk); #1;
        irq_req = 1'b0; insn_valid = 1'b0; cp_absent = 1'b0; cp_busy = 1'b0;
        check_eq("R8", {5'd0, take_irq, offer_n, done}, 8'b110);
        return;
      end
    end
    insn_valid = 1'b0; cp_absent = 1'b0; cp_busy = 1'b0; irq_req = irq_drop;
    #1;
    check_eq("R7", {7'd0, stall}, 8'd0);
    exp_q.push_back(EV_DONE);
    @(posedge clk); #1;
    irq_req = 1'b0;
    check_eq(irq_drop ? "R11" : "R7", {5'd0, done, take_irq, offer_n}, 8'b101);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1", {3'd0, offer_n, stall, undef_trap, take_irq, done}, 8'b10000);
    rst = 1'b0;
    @(posedge clk); #1;
    check_eq("R1", {3'd0, offer_n, stall, undef_trap, take_irq, done}, 8'b10000);

    issue(1, 0, 0, 0, 0, 0, 0);   // R5 immediate completion
    issue(0, 0, 1, 0, 0, 0, 0);   // R2 failed condition, absent noise
    issue(1, 1, 0, 2, 0, 0, 0);   // R2 branch shadow, busy noise
    issue(1, 0, 1, 0, 0, 0, 0);   // R4 trap
    issue(1, 0, 1, 1, 0, 0, 0);   // R4 absent dominates busy
    issue(1, 0, 0, 3, 0, 0, 0);   // R6 R7 three busy cycles
    issue(1, 0, 0, 1, 0, 0, 0);   // R6 R7 single busy cycle
    issue(1, 0, 0, 4, 1, 0, 0);   // R8 abandon on interrupt
    issue(1, 0, 0, 0, 0, 0, 0);   // R8 retry completes
    issue(1, 0, 0, 2, 0, 1, 0);   // R11 drop and interrupt together
    issue(1, 0, 0, 3, 0, 0, 1);   // R9 noise during wait
    issue(1, 0, 0, 1, 1, 0, 0);   // R8 abandon after one cycle
    issue(1, 0, 0, 2, 0, 0, 0);   // R8 retry through a wait

    repeat (3) @(posedge clk);
    #1;
    check_eq("R10", exp_q.size(), 8'd0);
    finish_run();
  end

endmodule